// File: doc/BRIEF.md
# Dual Privilege-Filtered Event Counter

This block holds two independent 40-bit event counters for performance monitoring. Each counter has a 9-bit function register. The function register picks one line from a 64-wide vector of per-cycle event inputs. It also decides which privilege modes are counted, and whether the counter tallies separate occurrences of the event or every cycle in which the event is active. A single input tells the block whether the processor is in user mode or kernel mode during the current cycle.

Software-side logic reaches the block through a small register port. One write strobe with a select code updates either a function register or a counter value. A registered read path returns either counter. The event codes form a sparse set. A function write that carries an unassigned code is refused and reported. When a counter wraps past its maximum value, the block raises a one-cycle overflow pulse for that counter.

Top module: `evctr_top`

## Requirements
- R1: After a synchronous active-high reset, both counters and both function registers are zero. `rd_data`, `ovf` and `fn_err` are zero, and no counter advances while its function is still zero.
- R2: Function word layout: bit 8 enables counting in kernel mode, bit 7 enables counting in user mode, bit 6 selects cycle (duration) mode, and bits 5:0 are the event code. Code n selects `ev_in[n]`.
- R3: The assigned event codes are 0x00–0x0F, 0x12–0x1F and 0x22–0x29. A function write with any other code raises `fn_err` for exactly one cycle and leaves that function register unchanged.
- R4: A counter advances only when the flag for the current mode is set. With `priv_user`=1 this is the user flag; with `priv_user`=0 it is the kernel flag. With both flags clear the counter never advances.
- R5: In occurrence mode (bit 6 = 0), a counter adds one in each cycle where the selected event is 1 and was 0 in the previous cycle.
- R6: In cycle mode (bit 6 = 1), a counter adds one in every cycle where the selected event is 1.
- R7: A counter at all-ones that increments becomes zero. Its `ovf` bit (bit i for counter i) is 1 for exactly the one cycle in which the counter first reads zero.
- R8: A counter write in the same cycle as an increment stores the written value, and that write does not pulse `ovf`.
- R9: Register port: `reg_sel` 0 and 1 write function registers 0 and 1 from `reg_wdata[8:0]`. `reg_sel` 2 and 3 write counters 0 and 1 from `reg_wdata`. After each clock edge, `rd_data` holds the value that counter `rd_sel` had just before that edge.
- R10: The two counters count independently, each under its own function register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| priv_user | input | 1 | 1 = user mode this cycle, 0 = kernel mode |
| ev_in | input | 64 | Per-cycle event lines, indexed by event code |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0/1 function, 2/3 counter |
| reg_wdata | input | 40 | Write data |
| rd_sel | input | 1 | Counter shown on rd_data |
| rd_data | output | 40 | Registered counter read value |
| ovf | output | 2 | One-cycle wrap pulse per counter |
| fn_err | output | 1 | One-cycle pulse on a refused function write |

## Verification
The assertions assume that `ev_in` and `priv_user` are sampled once per clock and may change freely between edges. They also assume that a counter write and its increment can coincide, so that write priority is always exercised. The stimulus drives every input away from the active edge. It mixes random event vectors and privilege changes with random function codes, some of them unassigned. Counter writes are biased toward values just below all-ones so that wraps appear within a few hundred cycles.

// File: rtl/evctr_pkg.sv
`timescale 1ns/1ps
package evctr_pkg;
  localparam int CODE_W = 6;
  localparam int FN_W   = 3 + CODE_W;

  typedef struct packed {
    logic              kern;
    logic              user;
    logic              dur;
    logic [CODE_W-1:0] code;
  } fn_t;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c <= 6'h0f) || (c >= 6'h12 && c <= 6'h1f) || (c >= 6'h22 && c <= 6'h29);
  endfunction
endpackage

// File: rtl/evctr_fnreg.sv
`timescale 1ns/1ps
module evctr_fnreg
  import evctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  fn_t  wdata_i,
  output fn_t  fn_o,
  output logic err_o
);
  fn_t  fn_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_i && !code_ok(wdata_i.code);
      if (wr_i && code_ok(wdata_i.code)) fn_q <= wdata_i;
    end
  end

  assign fn_o  = fn_q;
  assign err_o = err_q;

  // R3: refused code keeps the old function and flags it
  p_bad_code_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !code_ok(wdata_i.code)) |=> (fn_q == $past(fn_q)) && err_q);

  // R2: accepted code is stored without error
  p_good_code_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && code_ok(wdata_i.code)) |=> (fn_q == $past(wdata_i)) && !err_q);
endmodule

// File: rtl/evctr_count.sv
`timescale 1ns/1ps
module evctr_count
  import evctr_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int NUM_EV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  fn_t               fn_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              priv_user_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             prev_q;
  logic             ev_sel, mode_ok, hit, inc;

  always_comb begin
    ev_sel  = ev_i[fn_i.code];
    mode_ok = priv_user_i ? fn_i.user : fn_i.kern;
    hit     = fn_i.dur ? ev_sel : (ev_sel & ~prev_q);
    inc     = mode_ok & code_ok(fn_i.code) & hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= ev_sel;
      ovf_q  <= 1'b0;
      if (wr_i) begin
        cnt_q <= wdata_i;
      end else if (inc) begin
        cnt_q <= cnt_q + CNT_W'(1);
        ovf_q <= (cnt_q == ALL_ONES);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R7: a wrap pulse only appears with the counter at zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0));

  // R8: a write lands unchanged and never pulses overflow
  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (cnt_q == $past(wdata_i)) && !ovf_q);

  // R4: mode flag clear for the current mode freezes the counter
  p_mode_filter_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !(priv_user_i ? fn_i.user : fn_i.kern)) |=> (cnt_q == $past(cnt_q)));

  // R5: no count while the selected line stays high in occurrence mode
  p_occ_once_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !fn_i.dur && prev_q) |=> (cnt_q == $past(cnt_q)));

  // R6: without a write the counter moves by at most one
  p_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/evctr_top.sv
`timescale 1ns/1ps
module evctr_top
  import evctr_pkg::*;
#(
  parameter  int CNT_W   = 40,
  parameter  int NUM_CTR = 2,
  localparam int NUM_EV  = 1 << CODE_W,
  localparam int SEL_W   = $clog2(2 * NUM_CTR),
  localparam int RD_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               priv_user,
  input  logic [NUM_EV-1:0]  ev_in,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [CNT_W-1:0]   reg_wdata,
  input  logic [RD_W-1:0]    rd_sel,
  output logic [CNT_W-1:0]   rd_data,
  output logic [NUM_CTR-1:0] ovf,
  output logic               fn_err
);
  logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
  logic [NUM_CTR-1:0] err_vec;
  logic [CNT_W-1:0]   rd_q;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    fn_t  fn;
    logic fn_wr, ct_wr;

    assign fn_wr = reg_wr && (reg_sel == SEL_W'(g));
    assign ct_wr = reg_wr && (reg_sel == SEL_W'(NUM_CTR + g));

    evctr_fnreg u_fn (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (fn_wr),
      .wdata_i (fn_t'(reg_wdata[FN_W-1:0])),
      .fn_o    (fn),
      .err_o   (err_vec[g])
    );

    evctr_count #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .fn_i        (fn),
      .ev_i        (ev_in),
      .priv_user_i (priv_user),
      .wr_i        (ct_wr),
      .wdata_i     (reg_wdata),
      .cnt_o       (cnt_arr[g]),
      .ovf_o       (ovf[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= cnt_arr[rd_sel];
  end

  assign rd_data = rd_q;
  assign fn_err  = |err_vec;

  // R3: an error pulse always follows a register write
  p_err_after_write_r3: assert property (@(posedge clk) disable iff (rst)
    fn_err |-> $past(reg_wr));

  // R7: overflow bits are single-cycle pulses
  p_ovf_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf != '0) |=> ((ovf & $past(ovf)) == '0));
endmodule

// File: tb/evctr_top_tb_top.sv
`timescale 1ns/1ps
module evctr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        priv_user;
  logic [63:0] ev_in;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [39:0] reg_wdata;
  logic [0:0]  rd_sel;
  logic [39:0] rd_data;
  logic [1:0]  ovf;
  logic        fn_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [39:0] m_cnt [2];
  logic [8:0]  m_fn  [2];
  logic        m_prev[2];
  logic [63:0] g_ev;
  logic        g_usr;

  always #10 clk = ~clk;

  evctr_top dut_i (
    .clk(clk), .rst(rst), .priv_user(priv_user), .ev_in(ev_in),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .ovf(ovf), .fn_err(fn_err)
  );

  function automatic bit unassigned(input logic [5:0] c);
    return c inside {[6'h10:6'h11], [6'h20:6'h21], [6'h2a:6'h3f]};
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, compare at the following negedge
  task automatic step(input string tag, input logic wr, input logic [1:0] sel,
                      input logic [39:0] wd, input logic rs);
    logic [39:0] e_rd;
    logic [1:0]  e_ovf;
    logic        e_err;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; rd_sel = rs;
    ev_in = g_ev; priv_user = g_usr;
    e_rd = m_cnt[rs]; e_ovf = 2'b00; e_err = 1'b0;
    for (int i = 0; i < 2; i++) begin
      logic es, allow, hit;
      es    = g_ev[m_fn[i][5:0]];
      allow = g_usr ? m_fn[i][7] : m_fn[i][8];
      hit   = m_fn[i][6] ? es : (es && !m_prev[i]);
      m_prev[i] = es;
      if (wr && sel == 2'(2 + i)) m_cnt[i] = wd;
      else if (allow && !unassigned(m_fn[i][5:0]) && hit) begin
        if (m_cnt[i] == 40'hFF_FFFF_FFFF) begin
          m_cnt[i] = '0;
          e_ovf[i] = 1'b1;
        end else m_cnt[i] = m_cnt[i] + 40'd1;
      end
      if (wr && sel == 2'(i)) begin
        if (unassigned(wd[5:0])) e_err = 1'b1;
        else m_fn[i] = wd[8:0];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, e_rd);
    check("R7", {38'd0, ovf}, {38'd0, e_ovf});
    check("R3", {39'd0, fn_err}, {39'd0, e_err});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; rd_sel = 0;
    ev_in = '0; priv_user = 0;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_fn[i] = '0; m_prev[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1", rd_data, 40'd0);
    check("R1", {38'd0, ovf}, 40'd0);
    check("R1", {39'd0, fn_err}, 40'd0);
    rst = 1'b0;

    // R1: zero functions ignore active events
    g_ev = '1; g_usr = 1'b1;
    repeat (3) step("R1", 0, 2'd0, 40'd0, 1'b0);
    repeat (2) step("R1", 0, 2'd0, 40'd0, 1'b1);

    // R9: counter writes and registered reads
    step("R9", 1, 2'd2, 40'h12_3456_789A, 1'b0);
    step("R9", 0, 2'd0, 40'd0, 1'b0);
    step("R9", 1, 2'd3, 40'hA5_5A5A_A5A5, 1'b1);
    step("R9", 0, 2'd0, 40'd0, 1'b1);

    // R4: privilege filter
    g_ev = '0;
    step("R4", 1, 2'd0, 40'h043, 1'b0);
    g_ev[3] = 1'b1;
    repeat (3) step("R4", 0, 2'd0, 40'd0, 1'b0);
    step("R4", 1, 2'd0, 40'h143, 1'b0);
    repeat (3) step("R4", 0, 2'd0, 40'd0, 1'b0);
    g_usr = 1'b0;
    repeat (3) step("R4", 0, 2'd0, 40'd0, 1'b0);
    g_usr = 1'b1;

    // R5: occurrence counting on code 5 (R2 layout)
    step("R2", 1, 2'd0, 40'h085, 1'b0);
    for (int k = 0; k < 12; k++) begin
      g_ev[5] = 12'b0110_1110_0101 >> k;
      step("R5", 0, 2'd0, 40'd0, 1'b0);
    end

    // R6: cycle counting on code 7
    step("R2", 1, 2'd1, 40'h0C7, 1'b1);
    for (int k = 0; k < 12; k++) begin
      g_ev[7] = 12'b1110_0111_0100 >> k;
      step("R6", 0, 2'd0, 40'd0, 1'b1);
    end

    // R3: unassigned codes refused, counting continues under old function
    step("R3", 1, 2'd0, 40'h111, 1'b0);
    step("R3", 1, 2'd1, 40'h1A0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      g_ev[5] = k[0];
      step("R3", 0, 2'd0, 40'd0, 1'b0);
    end

    // R7: wrap with cycle counting
    g_ev = '1;
    step("R7", 1, 2'd3, 40'hFF_FFFF_FFFE, 1'b1);
    repeat (4) step("R7", 0, 2'd0, 40'd0, 1'b1);

    // R8: write wins over increment
    step("R8", 1, 2'd3, 40'hFF_FFFF_FFFF, 1'b1);
    step("R8", 1, 2'd3, 40'd5, 1'b1);
    repeat (2) step("R8", 0, 2'd0, 40'd0, 1'b1);

    // R10: random mix, both counters independent
    for (int n = 0; n < 3000; n++) begin
      logic        wr;
      logic [1:0]  sel;
      logic [39:0] wd;
      wr  = ($urandom % 4) == 0;
      sel = 2'($urandom % 4);
      if (sel < 2) wd = 40'($urandom % 512);
      else if (($urandom % 2) == 0) wd = {32'hFFFF_FFFF, 8'($urandom)};
      else wd = {8'($urandom), 32'($urandom)};
      g_ev  = {32'($urandom), 32'($urandom)};
      g_usr = 1'($urandom);
      step("R10", wr, sel, wd, 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule